// File: doc/BRIEF.md
# Sequential Shift-Add Mantissa Multiplier

This block multiplies two normalized floating-point mantissas, each held as a
multi-word unsigned integer, and adds their exponents. A start pulse loads both
operands. The block then scans the multiplier Y one bit per cycle, starting at
the least significant bit. On every step the accumulator moves right by one
place and X is added when the current Y bit is set. Bits that fall off the
bottom of the accumulator are collected into a sticky flag. A Y word that is
entirely zero costs one cycle, in which the accumulator moves right by a whole
word. If that zero word is the lowest one, the accumulator does not move at all,
because it still holds zero.

The mantissa layout is set by parameters. Each operand has `N_WORDS` words of
`WORD_W` bits. The leading one sits at bit `LEAD = (N_WORDS-1)*WORD_W + GUARD`,
and the lowest `GUARD` bits are guard bits. When the scan ends, one
normalization cycle shifts the product right once more if its integer part has
reached 2, and increments the exponent in that case. The block then pulses
`done` and holds the result until the next operation finishes. The caller must
supply normal operands: bit `LEAD` set and nothing above it in both mantissas,
and the Y guard bits clear. Rounding, special operands and packing to a memory
format are left to neighbouring logic.

Top module: `mant_mul`

## Requirements
- R1: After reset, `busy`, `done`, `p_mant`, `p_exp`, `p_sign` and `p_sticky` are all zero.
- R2: A `start` sampled while the block is idle loads the operands, and `busy` is high from the next cycle. A `start` sampled while `busy` is high is ignored: the result still belongs to the first operation.
- R3: `p_mant` equals the full product X*Y shifted right by `LEAD` places. If bit 2*LEAD+1 of the full product is set, the shift is `LEAD+1` places instead. As a result, bit `LEAD` of `p_mant` is set and every bit above it is clear.
- R4: `p_sticky` is 1 exactly when at least one bit that R3 discards from the full product is nonzero.
- R5: `p_exp` equals `x_exp + y_exp` modulo 2^EXP_W, plus 1 when R3 applies the extra shift.
- R6: `p_sign` is the XOR of `x_sign` and `y_sign`.
- R7: Counted in clock edges after the edge that samples `start`, `done` is high after L edges. L is the sum of the following: 1 for the normalization cycle; for word 0 of Y, 1 if it is zero and otherwise WORD_W-GUARD; for each middle word, 1 if it is zero and otherwise WORD_W; for the top word, its highest set bit position plus 1.
- R8: `done` is high for exactly one cycle, and `busy` is low in that cycle. The result outputs change only in the cycle in which `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse; accepted only when idle |
| x_mant | input | N_WORDS*WORD_W | Multiplicand mantissa |
| y_mant | input | N_WORDS*WORD_W | Multiplier mantissa; guard bits must be zero |
| x_exp | input | EXP_W | Exponent of X |
| y_exp | input | EXP_W | Exponent of Y |
| x_sign | input | 1 | Sign of X |
| y_sign | input | 1 | Sign of Y |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when the result is updated |
| p_mant | output | N_WORDS*WORD_W | Normalized product mantissa |
| p_exp | output | EXP_W | Product exponent |
| p_sign | output | 1 | Product sign |
| p_sticky | output | 1 | OR of all discarded product bits |

## Verification
The assertions check the handshake on every cycle. They cover acceptance of `start` into `busy`, the one-cycle `done` pulse, and the rule that results move only when `done` rises. They also check that every finished mantissa is normalized. Only the bench scenarios can show that the mantissa, sticky flag and exponent match a full-width reference product. The same holds for the cycle count that follows each zero-word pattern, and for the rule that a `start` arriving mid-operation leaves the result untouched.

// File: rtl/mant_mul.sv
module mant_mul #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 4,
  parameter int GUARD   = 2,
  parameter int EXP_W   = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [N_WORDS*WORD_W-1:0]   x_mant,
  input  logic [N_WORDS*WORD_W-1:0]   y_mant,
  input  logic [EXP_W-1:0]            x_exp,
  input  logic [EXP_W-1:0]            y_exp,
  input  logic                        x_sign,
  input  logic                        y_sign,
  output logic                        busy,
  output logic                        done,
  output logic [N_WORDS*WORD_W-1:0]   p_mant,
  output logic [EXP_W-1:0]            p_exp,
  output logic                        p_sign,
  output logic                        p_sticky
);
  localparam int MANT_W = N_WORDS * WORD_W;
  localparam int LEAD   = (N_WORDS - 1) * WORD_W + GUARD;
  localparam int WIDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
  localparam int BIDX_W = $clog2(WORD_W);

  typedef enum logic [1:0] {IDLE, RUN, NORM} state_t;
  state_t state;

  logic [MANT_W-1:0] acc, xr, yr;
  logic [EXP_W-1:0]  esum;
  logic              sgn, sticky;
  logic [WIDX_W-1:0] widx;
  logic [BIDX_W-1:0] bidx;

  logic [WORD_W-1:0] ycur;
  logic              last_word, word_zero, rest_zero, end_of_word, ovf;
  logic [MANT_W-1:0] acc_step;

  assign ycur        = yr[widx*WORD_W +: WORD_W];
  assign last_word   = (widx == WIDX_W'(N_WORDS - 1));
  assign word_zero   = (ycur == '0);
  assign rest_zero   = ((ycur >> bidx) >> 1) == '0;
  assign end_of_word = (bidx == BIDX_W'(WORD_W - 1)) || (last_word && rest_zero);
  assign acc_step    = (acc >> 1) + (ycur[bidx] ? xr : '0);
  assign ovf         = acc[LEAD+1];
  assign busy        = (state != IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= IDLE;
      acc      <= '0;
      xr       <= '0;
      yr       <= '0;
      esum     <= '0;
      sgn      <= 1'b0;
      sticky   <= 1'b0;
      widx     <= '0;
      bidx     <= '0;
      done     <= 1'b0;
      p_mant   <= '0;
      p_exp    <= '0;
      p_sign   <= 1'b0;
      p_sticky <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        IDLE: if (start) begin
          xr     <= x_mant;
          yr     <= y_mant;
          esum   <= x_exp + y_exp;
          sgn    <= x_sign ^ y_sign;
          acc    <= '0;
          sticky <= 1'b0;
          widx   <= '0;
          bidx   <= BIDX_W'(GUARD);
          state  <= RUN;
        end
        RUN: begin
          if (word_zero && !last_word) begin
            if (widx != '0) begin
              acc    <= acc >> WORD_W;
              sticky <= sticky | (|acc[WORD_W-1:0]);
            end
            widx <= widx + 1'b1;
            bidx <= '0;
          end else begin
            acc    <= acc_step;
            sticky <= sticky | acc[0];
            if (end_of_word) begin
              if (last_word) state <= NORM;
              else begin
                widx <= widx + 1'b1;
                bidx <= '0;
              end
            end else begin
              bidx <= bidx + 1'b1;
            end
          end
        end
        NORM: begin
          p_mant   <= ovf ? (acc >> 1) : acc;
          p_sticky <= sticky | (ovf & acc[0]);
          p_exp    <= esum + EXP_W'(ovf);
          p_sign   <= sgn;
          done     <= 1'b1;
          state    <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mant_mul_chk.sv
module mant_mul_chk #(
  parameter int MANT_W = 128,
  parameter int LEAD   = 98,
  parameter int EXP_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [MANT_W-1:0] p_mant,
  input logic [EXP_W-1:0]  p_exp,
  input logic              p_sticky
);
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(p_mant) && $stable(p_exp) && $stable(p_sticky)) |-> done);

  assert_normalized_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (p_mant[LEAD] && (p_mant >> (LEAD + 1)) == '0));
endmodule

bind mant_mul mant_mul_chk #(.MANT_W(MANT_W), .LEAD(LEAD), .EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .p_mant(p_mant), .p_exp(p_exp), .p_sticky(p_sticky)
);

// File: tb/mant_mul_tb.sv
module mant_mul_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WW = 32, NW = 4, G = 2, EW = 16;
  localparam int MW = WW * NW;
  localparam int LD = (NW - 1) * WW + G;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [MW-1:0] x_mant = '0, y_mant = '0;
  logic [EW-1:0] x_exp = '0, y_exp = '0;
  logic x_sign = 1'b0, y_sign = 1'b0;
  logic busy, done, p_sign, p_sticky;
  logic [MW-1:0] p_mant;
  logic [EW-1:0] p_exp;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mant_mul #(.WORD_W(WW), .N_WORDS(NW), .GUARD(G), .EXP_W(EW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .x_mant(x_mant), .y_mant(y_mant),
    .x_exp(x_exp), .y_exp(y_exp), .x_sign(x_sign), .y_sign(y_sign),
    .busy(busy), .done(done), .p_mant(p_mant), .p_exp(p_exp),
    .p_sign(p_sign), .p_sticky(p_sticky));

  task automatic check(input bit ok, input string req, input logic [MW-1:0] act, input logic [MW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [MW-1:0] mk_norm(input bit clr_guard);
    logic [MW-1:0] v;
    v = {$urandom, $urandom, $urandom, $urandom};
    v = v & ((MW'(1) << (LD + 1)) - 1);
    v[LD] = 1'b1;
    if (clr_guard) v[G-1:0] = '0;
    return v;
  endfunction

  function automatic int latency(input logic [MW-1:0] y);
    int l, hb;
    l = 1;
    for (int w = 0; w < NW - 1; w++) begin
      if (y[w*WW +: WW] == '0) l += 1;
      else l += (w == 0) ? (WW - G) : WW;
    end
    hb = 0;
    for (int b = 0; b < WW; b++) if (y[(NW-1)*WW + b]) hb = b;
    return l + hb + 1;
  endfunction

  task automatic run_op(input logic [MW-1:0] x, input logic [MW-1:0] y,
                        input logic [EW-1:0] ex, input logic [EW-1:0] ey,
                        input logic sx, input logic sy, input bit poke);
    logic [2*MW-1:0] prod, lost;
    logic [MW-1:0] e_mant;
    logic [EW-1:0] e_exp;
    bit ov;
    int sh, n, lat;
    prod = {{MW{1'b0}}, x} * {{MW{1'b0}}, y};
    ov = prod[2*LD+1];
    sh = LD + int'(ov);
    e_mant = MW'(prod >> sh);
    lost = prod & (({{(2*MW-1){1'b0}}, 1'b1} << sh) - 1);
    e_exp = ex + ey + EW'(ov);
    lat = latency(y);

    @(negedge clk);
    x_mant = x; y_mant = y; x_exp = ex; y_exp = ey; x_sign = sx; y_sign = sy;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R2 busy after start", MW'(busy), MW'(1));
    n = 0;
    while (done !== 1'b1 && n < 400) begin
      if (poke && n == 3) begin
        start = 1'b1; x_mant = ~x; y_mant = ~y; x_exp = ~ex; x_sign = ~sx;
      end else start = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    check(n == lat, "R7 latency", MW'(n), MW'(lat));
    check(p_mant === e_mant, poke ? "R2 start while busy ignored" : "R3 mantissa", p_mant, e_mant);
    check(p_sticky === (lost != '0), "R4 sticky", MW'(p_sticky), MW'(lost != '0));
    check(p_exp === e_exp, "R5 exponent", MW'(p_exp), MW'(e_exp));
    check(p_sign === (sx ^ sy), "R6 sign", MW'(p_sign), MW'(sx ^ sy));
    check(busy === 1'b0, "R8 idle with done", MW'(busy), MW'(0));
    @(negedge clk);
    check(done === 1'b0 && p_mant === e_mant, "R8 done pulse and hold", MW'(done), MW'(0));
  endtask

  initial begin
    logic [MW-1:0] one, all1, x, y;
    void'($urandom(32'd1234));
    one  = MW'(1) << LD;
    all1 = (MW'(1) << (LD + 1)) - 1;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1 reset control", MW'({busy, done}), MW'(0));
    check(p_mant === '0 && p_exp === '0, "R1 reset mantissa/exponent", p_mant, MW'(0));
    check(p_sign === 1'b0 && p_sticky === 1'b0, "R1 reset sign/sticky", MW'({p_sign, p_sticky}), MW'(0));
    rst_n = 1'b1;

    run_op(one, one, 16'd5, 16'd7, 1'b0, 1'b0, 0);
    run_op(all1, all1 & ~MW'(3), 16'hFFFF, 16'd3, 1'b1, 1'b0, 0);
    run_op(all1, one | MW'(4), 16'd0, 16'd0, 1'b1, 1'b1, 0);
    y = mk_norm(1); y[WW +: WW] = '0; y[2*WW +: WW] = '0;
    run_op(mk_norm(0), y, 16'h7FFF, 16'd1, 1'b0, 1'b1, 0);
    run_op(mk_norm(0), mk_norm(1), 16'd10, 16'd20, 1'b0, 1'b1, 1);

    for (int i = 0; i < 40; i++) begin
      x = mk_norm($urandom_range(0, 1) == 1);
      y = mk_norm(1);
      for (int w = 0; w < NW - 1; w++)
        if ($urandom_range(0, 2) == 0) y[w*WW +: WW] = '0;
      run_op(x, y, EW'($urandom), EW'($urandom), 1'($urandom), 1'($urandom), i % 10 == 0);
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule